// File: doc/BRIEF.md
# DMA Transfer Queue Register Frontend

This block is the software-facing front of a single-channel DMA engine. A processor programs the parameters of the next transfer over a simple 32-bit register bus: source and destination addresses, two length fields, two strides and a mode word. Writing the submit register copies that parameter set into a small FIFO and stamps it with a transfer ID taken from a rolling pool of 32. Software learns which ID the next submission will get by reading the next-ID register. It learns whether the queue has room by reading the submit register back.

On the engine side, the oldest queued descriptor is offered through a request/acknowledge handshake. The engine executes one transfer at a time. It reports the end of a transfer with a one-cycle done pulse that carries the ID. Completions build up in a 32-bit done mask, one bit per ID. Two interrupt causes feed a pending register with a mask:
- start-of-transfer, raised when the engine takes a descriptor and queue space frees up;
- end-of-transfer, raised when a transfer finishes.

A transfer submitted in cyclic mode is offered to the engine again, with the same ID, each time it completes. This continues until software disables the channel.

Register map (byte offsets on `bus_addr`, all 32-bit):

| Offset | Register |
|---|---|
| 0x00 | control |
| 0x04 | mode |
| 0x08 | submit |
| 0x0C | next ID |
| 0x10 | source address |
| 0x14 | destination address |
| 0x18 | source stride |
| 0x1C | destination stride |
| 0x20 | X length |
| 0x24 | Y length |
| 0x28 | done mask |
| 0x2C | running ID |
| 0x30 | status |
| 0x34 | interrupt mask |
| 0x38 | interrupt pending |
| 0x3C | interrupt source |

Top module: `dma_queue_regs`

## Requirements
- R1: After reset, control, mode, next ID, done mask, pending and status all read 0, and the interrupt mask reads 0x3. `eng_req` and `irq` are low.
- R2: The address, stride, length and mode registers read back the value last written. A queued descriptor carries those values, as they stood at submission, onto the `eng_*` outputs.
- R3: Writing submit with bit 0 = 1 queues a descriptor only when control bit 0 (enable) is 1 and fewer than DEPTH (default 4) descriptors are queued. The descriptor takes the current next ID, and next ID then advances by one modulo 32. Any other submit write changes neither the queue nor next ID.
- R4: Reading submit returns 1 when the queue is full or the channel is disabled, and 0 otherwise.
- R5: `eng_req` is high when the channel is enabled, not paused, no transfer is running and a descriptor is available. Descriptors are offered oldest first. A cycle with `eng_req` and `eng_ack` both high removes the offered descriptor. That cycle also marks a transfer as running (status bit 0), loads its ID into the running-ID register and sets pending bit 0.
- R6: While control bit 1 (pause) is 1, `eng_req` stays low and queued descriptors are kept. Clearing pause lets them be offered again.
- R7: A `eng_done` pulse whose `eng_done_id` equals the running ID does three things: it sets done-mask bit ID, ends the running state and sets pending bit 1. A pulse with any other ID, or with nothing running, changes no state.
- R8: Queuing a descriptor clears the done-mask bit of the ID it receives.
- R9: Mode bit 0 selects cyclic mode. When a cyclic transfer completes, the same descriptor with the same ID is offered again before any queued one. Each pass sets its done bit and pending bit 1.
- R10: Writing 1 to a pending bit clears it. A mask bit of 1 blocks that cause. `irq` is the OR of the pending bits whose mask bit is 0, and the interrupt-source register reads that masked set.
- R11: Writing control with bit 0 = 0 does the following: empties the queue, drops the running transfer and any cyclic repeat, and drives `eng_req` low. Next ID and the done mask keep their values.
- R12: Status bit 0 shows a running transfer, bit 1 a pending cyclic repeat, and bits 15:8 the number of queued descriptors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on `bus_rdata` after the next edge |
| bus_addr | input | BUS_AW | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_req | output | 1 | A descriptor is offered to the engine |
| eng_ack | input | 1 | Engine takes the offered descriptor |
| eng_id | output | ID_W | Transfer ID of the offered descriptor |
| eng_src | output | AW | Source address |
| eng_dst | output | AW | Destination address |
| eng_src_stride | output | LW | Source stride |
| eng_dst_stride | output | LW | Destination stride |
| eng_xlen | output | LW | X length field |
| eng_ylen | output | LW | Y length field |
| eng_cyclic | output | 1 | Offered descriptor is cyclic |
| eng_done | input | 1 | One-cycle end-of-transfer pulse |
| eng_done_id | input | ID_W | ID carried by the end pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the queue to its limit and then submits once more. A design that accepted the extra write would lose a descriptor or burn an ID, which shows up in next ID and the occupancy field. It runs IDs all the way around the 32-entry pool to confirm the wrap to 0 and that reuse clears the stale done bit. It sends an end pulse with a foreign ID to catch a design that trusts any completion. It follows a cyclic transfer through two passes with another descriptor queued behind it: a wrong priority would hand out ID 2 instead of repeating ID 1. Finally, it disables the channel while a cyclic repeat is armed, to confirm that the flush drops both the queue and the repeat.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

   // register byte offsets
   localparam int OFS_CTRL    = 'h00;
   localparam int OFS_MODE    = 'h04;
   localparam int OFS_SUBMIT  = 'h08;
   localparam int OFS_NEXTID  = 'h0C;
   localparam int OFS_SRC     = 'h10;
   localparam int OFS_DST     = 'h14;
   localparam int OFS_SSTR    = 'h18;
   localparam int OFS_DSTR    = 'h1C;
   localparam int OFS_XLEN    = 'h20;
   localparam int OFS_YLEN    = 'h24;
   localparam int OFS_DONE    = 'h28;
   localparam int OFS_RUNID   = 'h2C;
   localparam int OFS_STATUS  = 'h30;
   localparam int OFS_IMASK   = 'h34;
   localparam int OFS_IPEND   = 'h38;
   localparam int OFS_ISRC    = 'h3C;

   // bit positions
   localparam int CTRL_EN     = 0;
   localparam int CTRL_PAUSE  = 1;
   localparam int MODE_CYC    = 0;
   localparam int INT_START   = 0;
   localparam int INT_END     = 1;
   localparam int N_INT       = 2;

   typedef enum logic [4:0] {
      RS_NONE, RS_CTRL, RS_MODE, RS_SUBMIT, RS_NEXTID,
      RS_SRC, RS_DST, RS_SSTR, RS_DSTR, RS_XLEN, RS_YLEN,
      RS_DONE, RS_RUNID, RS_STATUS, RS_IMASK, RS_IPEND, RS_ISRC
   } reg_sel_e;

endpackage

// File: rtl/dmaq_fifo.sv
module dmaq_fifo #(
   parameter int DEPTH = 4,
   parameter int WIDTH = 8,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic [CW-1:0]    count,
   output logic             full,
   output logic             empty
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("dmaq_fifo: DEPTH must be at least 1");
   end

   logic do_push, do_pop;
   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   if (DEPTH == 1) begin : g_single
      logic [WIDTH-1:0] hold;
      always_ff @(posedge clk) begin
         if (do_push) hold <= din;
      end
      assign dout = hold;
   end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      logic [WIDTH-1:0] mem [DEPTH];
      logic [PW-1:0]    wr_ptr, rd_ptr;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
         end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
         end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (do_push) mem[wr_ptr] <= din;
      end
      assign dout = mem[rd_ptr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 count <= '0;
      else if (flush)             count <= '0;
      else if (do_push && !do_pop) count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
   end

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> (count == CW'(DEPTH)));

   // R11
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);

endmodule

// File: rtl/dmaq_irq.sv
module dmaq_irq #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         mask_we,
   input  logic [N-1:0] mask_wd,
   input  logic         clr_we,
   input  logic [N-1:0] clr_wd,
   input  logic [N-1:0] raise,
   output logic [N-1:0] mask,
   output logic [N-1:0] pend,
   output logic         irq
);

   if (N < 1) begin : g_bad_n
      $error("dmaq_irq: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_cause
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask[i] <= 1'b1;
            pend[i] <= 1'b0;
         end else begin
            if (mask_we) mask[i] <= mask_wd[i];
            if (raise[i])                  pend[i] <= 1'b1;
            else if (clr_we && clr_wd[i])  pend[i] <= 1'b0;
         end
      end
   end

   assign irq = |(pend & ~mask);

   // R10
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((pend & $past(clr_wd & ~raise)) == '0));

   // R10
   raise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (raise != '0) |=> ((pend & $past(raise)) == $past(raise)));

endmodule

// File: rtl/dmaq_done_map.sv
module dmaq_done_map #(
   parameter int ID_COUNT = 32,
   localparam int ID_W = $clog2(ID_COUNT)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_en,
   input  logic [ID_W-1:0]     set_id,
   input  logic                clr_en,
   input  logic [ID_W-1:0]     clr_id,
   output logic [ID_COUNT-1:0] bits
);

   for (genvar i = 0; i < ID_COUNT; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  bits[i] <= 1'b0;
         else if (set_en && set_id == ID_W'(i))        bits[i] <= 1'b1;
         else if (clr_en && clr_id == ID_W'(i))        bits[i] <= 1'b0;
      end
   end

   // R8
   reuse_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !(set_en && set_id == clr_id)) |=> !bits[$past(clr_id)]);

   // R7
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> bits[$past(set_id)]);

endmodule

// File: rtl/dma_queue_regs.sv
module dma_queue_regs
   import dmaq_pkg::*;
#(
   parameter int BUS_AW   = 8,
   parameter int AW       = 32,
   parameter int LW       = 24,
   parameter int DEPTH    = 4,
   parameter int ID_COUNT = 32,
   localparam int ID_W    = $clog2(ID_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              eng_req,
   input  logic              eng_ack,
   output logic [ID_W-1:0]   eng_id,
   output logic [AW-1:0]     eng_src,
   output logic [AW-1:0]     eng_dst,
   output logic [LW-1:0]     eng_src_stride,
   output logic [LW-1:0]     eng_dst_stride,
   output logic [LW-1:0]     eng_xlen,
   output logic [LW-1:0]     eng_ylen,
   output logic              eng_cyclic,
   input  logic              eng_done,
   input  logic [ID_W-1:0]   eng_done_id,
   output logic              irq
);

   localparam int CW = $clog2(DEPTH + 1);
   localparam int DW = ID_W + 1 + 4 * LW + 2 * AW;

   if (BUS_AW < 6)                        begin : g_bad_bus  $error("BUS_AW too small for the register map"); end
   if (AW < 1 || AW > 32)                 begin : g_bad_aw   $error("AW must be 1..32"); end
   if (LW < 1 || LW > 32)                 begin : g_bad_lw   $error("LW must be 1..32"); end
   if (ID_COUNT < 2 || ID_COUNT > 32)     begin : g_bad_ids  $error("ID_COUNT must be 2..32"); end
   if (DEPTH < 1 || DEPTH + 1 >= ID_COUNT) begin : g_bad_dep $error("DEPTH must leave IDs unique in flight"); end

   // ---------------- address decode
   reg_sel_e sel;
   always_comb begin
      case (bus_addr)
         BUS_AW'(OFS_CTRL):   sel = RS_CTRL;
         BUS_AW'(OFS_MODE):   sel = RS_MODE;
         BUS_AW'(OFS_SUBMIT): sel = RS_SUBMIT;
         BUS_AW'(OFS_NEXTID): sel = RS_NEXTID;
         BUS_AW'(OFS_SRC):    sel = RS_SRC;
         BUS_AW'(OFS_DST):    sel = RS_DST;
         BUS_AW'(OFS_SSTR):   sel = RS_SSTR;
         BUS_AW'(OFS_DSTR):   sel = RS_DSTR;
         BUS_AW'(OFS_XLEN):   sel = RS_XLEN;
         BUS_AW'(OFS_YLEN):   sel = RS_YLEN;
         BUS_AW'(OFS_DONE):   sel = RS_DONE;
         BUS_AW'(OFS_RUNID):  sel = RS_RUNID;
         BUS_AW'(OFS_STATUS): sel = RS_STATUS;
         BUS_AW'(OFS_IMASK):  sel = RS_IMASK;
         BUS_AW'(OFS_IPEND):  sel = RS_IPEND;
         BUS_AW'(OFS_ISRC):   sel = RS_ISRC;
         default:             sel = RS_NONE;
      endcase
   end

   logic wr_ctrl, wr_submit;
   assign wr_ctrl   = bus_wr && (sel == RS_CTRL);
   assign wr_submit = bus_wr && (sel == RS_SUBMIT) && bus_wdata[0];

   // ---------------- parameter registers
   logic [1:0]      r_ctrl;
   logic            r_cyc;
   logic [AW-1:0]   r_src, r_dst;
   logic [LW-1:0]   r_sstr, r_dstr, r_xlen, r_ylen;
   logic [ID_W-1:0] next_id;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_ctrl <= '0;
         r_cyc  <= 1'b0;
         r_src  <= '0;
         r_dst  <= '0;
         r_sstr <= '0;
         r_dstr <= '0;
         r_xlen <= '0;
         r_ylen <= '0;
      end else if (bus_wr) begin
         case (sel)
            RS_CTRL: r_ctrl <= {bus_wdata[CTRL_PAUSE], bus_wdata[CTRL_EN]};
            RS_MODE: r_cyc  <= bus_wdata[MODE_CYC];
            RS_SRC:  r_src  <= bus_wdata[AW-1:0];
            RS_DST:  r_dst  <= bus_wdata[AW-1:0];
            RS_SSTR: r_sstr <= bus_wdata[LW-1:0];
            RS_DSTR: r_dstr <= bus_wdata[LW-1:0];
            RS_XLEN: r_xlen <= bus_wdata[LW-1:0];
            RS_YLEN: r_ylen <= bus_wdata[LW-1:0];
            default: ;
         endcase
      end
   end

   logic enabled, paused, flush;
   assign enabled = r_ctrl[CTRL_EN];
   assign paused  = r_ctrl[CTRL_PAUSE];
   assign flush   = wr_ctrl && !bus_wdata[CTRL_EN];

   // ---------------- queue
   logic [DW-1:0] q_din, q_dout;
   logic [CW-1:0] q_count;
   logic          q_full, q_empty, q_push, q_pop;

   assign q_push = wr_submit && enabled && !q_full && !flush;
   assign q_din  = {next_id, r_cyc, r_ylen, r_xlen, r_dstr, r_sstr, r_dst, r_src};

   dmaq_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (q_push),
      .pop   (q_pop),
      .din   (q_din),
      .dout  (q_dout),
      .count (q_count),
      .full  (q_full),
      .empty (q_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      next_id <= '0;
      else if (q_push) next_id <= (next_id == ID_W'(ID_COUNT - 1)) ? '0 : next_id + 1'b1;
   end

   // ---------------- run control
   logic          busy, rerun;
   logic [DW-1:0] act_desc, sel_desc;
   logic [ID_W-1:0] act_id;
   logic          act_cyc;
   logic          take, done_ok;

   assign act_id   = act_desc[DW-1 -: ID_W];
   assign act_cyc  = act_desc[DW-1-ID_W];
   assign sel_desc = rerun ? act_desc : q_dout;

   assign eng_req = enabled && !paused && !busy && (rerun || !q_empty);
   assign take    = eng_req && eng_ack && !flush;
   assign q_pop   = take && !rerun;
   assign done_ok = eng_done && busy && (eng_done_id == act_id) && !flush;

   assign {eng_id, eng_cyclic, eng_ylen, eng_xlen, eng_dst_stride,
           eng_src_stride, eng_dst, eng_src} = sel_desc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         rerun    <= 1'b0;
         act_desc <= '0;
      end else if (flush) begin
         busy  <= 1'b0;
         rerun <= 1'b0;
      end else if (take) begin
         busy     <= 1'b1;
         rerun    <= 1'b0;
         act_desc <= sel_desc;
      end else if (done_ok) begin
         busy  <= 1'b0;
         rerun <= act_cyc;
      end
   end

   // ---------------- completion map and interrupts
   logic [ID_COUNT-1:0] done_bits;
   logic [N_INT-1:0]    int_mask, int_pend, int_raise;

   dmaq_done_map #(.ID_COUNT(ID_COUNT)) u_done (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (done_ok),
      .set_id (act_id),
      .clr_en (q_push),
      .clr_id (next_id),
      .bits   (done_bits)
   );

   always_comb begin
      int_raise            = '0;
      int_raise[INT_START] = take;
      int_raise[INT_END]   = done_ok;
   end

   dmaq_irq #(.N(N_INT)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask_we (bus_wr && sel == RS_IMASK),
      .mask_wd (bus_wdata[N_INT-1:0]),
      .clr_we  (bus_wr && sel == RS_IPEND),
      .clr_wd  (bus_wdata[N_INT-1:0]),
      .raise   (int_raise),
      .mask    (int_mask),
      .pend    (int_pend),
      .irq     (irq)
   );

   // ---------------- read path
   logic [31:0] rmux;
   always_comb begin
      rmux = '0;
      case (sel)
         RS_CTRL:   rmux = 32'(r_ctrl);
         RS_MODE:   rmux = 32'(r_cyc);
         RS_SUBMIT: rmux = 32'(q_full || !enabled);
         RS_NEXTID: rmux = 32'(next_id);
         RS_SRC:    rmux = 32'(r_src);
         RS_DST:    rmux = 32'(r_dst);
         RS_SSTR:   rmux = 32'(r_sstr);
         RS_DSTR:   rmux = 32'(r_dstr);
         RS_XLEN:   rmux = 32'(r_xlen);
         RS_YLEN:   rmux = 32'(r_ylen);
         RS_DONE:   rmux = 32'(done_bits);
         RS_RUNID:  rmux = 32'(act_id);
         RS_STATUS: rmux = {16'h0, 8'(q_count), 6'h0, rerun, busy};
         RS_IMASK:  rmux = 32'(int_mask);
         RS_IPEND:  rmux = 32'(int_pend);
         RS_ISRC:   rmux = 32'(int_pend & ~int_mask);
         default:   rmux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rmux;
   end

   // ---------------- assertions
   // R3
   id_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_push |=> ((next_id == $past(next_id) + ID_W'(1)) ||
                  (next_id == '0 && $past(next_id) == ID_W'(ID_COUNT - 1))));

   // R5
   start_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (int_pend[INT_START] && !eng_req));

   // R7
   end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_ok |=> int_pend[INT_END]);

   // R11
   flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!eng_req && q_count == '0));

   // R6
   pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (paused && !bus_wr) |=> (q_count >= $past(q_count)));

endmodule

// File: tb/dma_queue_regs_tb.sv
module dma_queue_regs_tb;

   localparam int ID_W = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        eng_req, eng_ack = 1'b0, eng_cyclic, eng_done = 1'b0, irq;
   logic [ID_W-1:0] eng_id, eng_done_id = '0;
   logic [31:0] eng_src, eng_dst;
   logic [23:0] eng_src_stride, eng_dst_stride, eng_xlen, eng_ylen;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   dma_queue_regs u_dut (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_req(eng_req), .eng_ack(eng_ack), .eng_id(eng_id),
      .eng_src(eng_src), .eng_dst(eng_dst),
      .eng_src_stride(eng_src_stride), .eng_dst_stride(eng_dst_stride),
      .eng_xlen(eng_xlen), .eng_ylen(eng_ylen), .eng_cyclic(eng_cyclic),
      .eng_done(eng_done), .eng_done_id(eng_done_id), .irq(irq)
   );

   localparam logic [7:0] A_CTRL = 8'h00, A_MODE = 8'h04, A_SUB = 8'h08, A_NID = 8'h0C,
      A_SRC = 8'h10, A_DST = 8'h14, A_SSTR = 8'h18, A_DSTR = 8'h1C, A_XLEN = 8'h20,
      A_YLEN = 8'h24, A_DONE = 8'h28, A_RUN = 8'h2C, A_STAT = 8'h30, A_IMASK = 8'h34,
      A_IPEND = 8'h38, A_ISRC = 8'h3C;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic ack();
      @(negedge clk); eng_ack = 1'b1;
      @(negedge clk); eng_ack = 1'b0;
   endtask

   task automatic done(input logic [ID_W-1:0] id);
      @(negedge clk); eng_done = 1'b1; eng_done_id = id;
      @(negedge clk); eng_done = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 eng_req", 32'(eng_req), 0);
      chk("R1 irq", 32'(irq), 0);
      rd_chk("R1 ctrl", A_CTRL, 0);
      rd_chk("R1 mode", A_MODE, 0);
      rd_chk("R1 next id", A_NID, 0);
      rd_chk("R1 done mask", A_DONE, 0);
      rd_chk("R1 pending", A_IPEND, 0);
      rd_chk("R1 status", A_STAT, 0);
      rd_chk("R1 mask", A_IMASK, 3);
      rd_chk("R4 submit while disabled", A_SUB, 1);
   endtask

   task automatic t_regs();
      wr(A_SRC, 32'h1000_0040); wr(A_DST, 32'h2000_0080);
      wr(A_SSTR, 32'h0000_0100); wr(A_DSTR, 32'h0000_0200);
      wr(A_XLEN, 32'h0000_003F); wr(A_YLEN, 32'h0000_0007);
      rd_chk("R2 src", A_SRC, 32'h1000_0040);
      rd_chk("R2 dst", A_DST, 32'h2000_0080);
      rd_chk("R2 src stride", A_SSTR, 32'h100);
      rd_chk("R2 dst stride", A_DSTR, 32'h200);
      rd_chk("R2 xlen", A_XLEN, 32'h3F);
      rd_chk("R2 ylen", A_YLEN, 32'h7);
   endtask

   task automatic t_pause();
      wr(A_CTRL, 3);
      rd_chk("R4 submit ready", A_SUB, 0);
      wr(A_SUB, 1);
      @(negedge clk);
      chk("R6 paused no req", 32'(eng_req), 0);
      rd_chk("R12 occupancy 1", A_STAT, 32'h100);
      wr(A_CTRL, 1);
      chk("R6 resume req", 32'(eng_req), 1);
      chk("R2 eng_src", eng_src, 32'h1000_0040);
      chk("R2 eng_dst", eng_dst, 32'h2000_0080);
      chk("R2 eng_xlen", 32'(eng_xlen), 32'h3F);
      chk("R2 eng_ylen", 32'(eng_ylen), 32'h7);
      chk("R2 eng_dst_stride", 32'(eng_dst_stride), 32'h200);
      chk("R5 eng_id", 32'(eng_id), 0);
   endtask

   task automatic t_handoff();
      wr(A_IMASK, 0);
      ack();
      chk("R5 req drops while running", 32'(eng_req), 0);
      chk("R10 irq on start", 32'(irq), 1);
      rd_chk("R5 pending start", A_IPEND, 1);
      rd_chk("R5 running id", A_RUN, 0);
      rd_chk("R12 busy", A_STAT, 1);
      wr(A_IPEND, 1);
      chk("R10 irq cleared", 32'(irq), 0);
      rd_chk("R10 pending cleared", A_IPEND, 0);
   endtask

   task automatic t_done();
      done(5);
      rd_chk("R7 foreign id ignored mask", A_DONE, 0);
      rd_chk("R7 foreign id still busy", A_STAT, 1);
      rd_chk("R7 foreign id no pending", A_IPEND, 0);
      done(0);
      rd_chk("R7 done bit", A_DONE, 1);
      rd_chk("R7 pending end", A_IPEND, 2);
      rd_chk("R12 idle", A_STAT, 0);
      done(0);
      rd_chk("R7 idle done ignored", A_IPEND, 2);
      wr(A_IPEND, 3);
   endtask

   task automatic t_full_order();
      for (int k = 0; k < 4; k++) begin
         wr(A_SRC, 32'h3000_0000 + 32'(k));
         wr(A_SUB, 1);
      end
      rd_chk("R3 next id after four", A_NID, 5);
      rd_chk("R4 submit full", A_SUB, 1);
      wr(A_SUB, 1);
      rd_chk("R3 full write ignored id", A_NID, 5);
      rd_chk("R3 full occupancy", A_STAT, 32'h400);
      for (int k = 0; k < 4; k++) begin
         chk("R5 order id", 32'(eng_id), 32'(k + 1));
         chk("R5 order src", eng_src, 32'h3000_0000 + 32'(k));
         ack();
         done(ID_W'(k + 1));
      end
      rd_chk("R7 mask ids 0..4", A_DONE, 32'h1F);
      wr(A_IMASK, 3);
      chk("R10 masked irq", 32'(irq), 0);
      rd_chk("R10 pending kept", A_IPEND, 3);
      rd_chk("R10 source masked", A_ISRC, 0);
      wr(A_IMASK, 1);
      chk("R10 end cause irq", 32'(irq), 1);
      rd_chk("R10 source end only", A_ISRC, 2);
      wr(A_IPEND, 3);
      wr(A_IMASK, 0);
   endtask

   task automatic t_wrap();
      for (int k = 5; k < 32; k++) begin
         wr(A_SUB, 1);
         ack();
         done(ID_W'(k));
      end
      rd_chk("R3 id wraps to 0", A_NID, 0);
      rd_chk("R7 all done", A_DONE, 32'hFFFF_FFFF);
      wr(A_SUB, 1);
      rd_chk("R8 reuse clears bit", A_DONE, 32'hFFFF_FFFE);
      ack();
      done(0);
      wr(A_IPEND, 3);
   endtask

   task automatic t_cyclic();
      wr(A_MODE, 1);
      rd_chk("R2 mode readback", A_MODE, 1);
      wr(A_SUB, 1);
      wr(A_MODE, 0);
      wr(A_SUB, 1);
      chk("R9 cyclic flag", 32'(eng_cyclic), 1);
      chk("R9 first id", 32'(eng_id), 1);
      ack();
      done(1);
      chk("R9 repeat offered", 32'(eng_req), 1);
      chk("R9 repeat same id", 32'(eng_id), 1);
      rd_chk("R12 repeat and queued", A_STAT, 32'h102);
      ack();
      wr(A_IPEND, 3);
      done(1);
      chk("R9 second repeat id", 32'(eng_id), 1);
      rd_chk("R9 end pending each pass", A_IPEND, 2);
      rd_chk("R9 done bit set", A_DONE[7:0] == A_DONE[7:0] ? A_DONE : A_DONE, 32'hFFFF_FFFB);
   endtask

   task automatic t_disable();
      wr(A_CTRL, 0);
      chk("R11 req low", 32'(eng_req), 0);
      rd_chk("R11 status cleared", A_STAT, 0);
      rd_chk("R11 next id kept", A_NID, 3);
      rd_chk("R11 done kept", A_DONE, 32'hFFFF_FFFB);
      wr(A_SUB, 1);
      rd_chk("R3 disabled write ignored", A_NID, 3);
      rd_chk("R4 disabled not ready", A_SUB, 1);
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_pause();
      t_handoff();
      t_done();
      t_full_order();
      t_wrap();
      t_cyclic();
      t_disable();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule